// File: doc/BRIEF.md
# Receive Capture Offload Controller

This block sits between a converter's receive interface and a DMA engine. It captures a fixed-size block of samples into on-chip storage and then hands the whole block to the DMA as a single stream packet. Software or system logic arms it with a one-cycle initialization request. The controller answers with a level acknowledge while it is willing to take samples. Capture begins on the start event chosen by a two-bit mode input: at once in automatic mode, on an external trigger pulse in hardware mode, or on a one-cycle software strobe in software mode.

The device side has no back-pressure. Each cycle with the write-valid bit high carries one packed beat. Beats that arrive after the storage has filled are dropped and raise a sticky overflow flag. Once the storage holds `DEPTH` beats, readout begins on a valid/ready stream master. The stream follows the usual rules: a beat moves only on a cycle with valid and ready both high, and while ready is low the presented beat, its data and its last flag stay unchanged. The final beat of the block carries the last flag. A bypass input routes device beats straight to the stream output through one register stage, without storing them. A 64-bit counter reports how many beats the current capture has stored.

Top module: `rxo_capture_offload`

## Requirements
- R1: One cycle after `init_req` is sampled high, `init_ack` is high. It stays high until the storage is full. It is low after reset and during readout.
- R2: With `sync_mode` = 0 (automatic), a beat written in the first cycle in which `init_ack` reads high is stored as beat 0.
- R3: With `sync_mode` = 1 (hardware), device writes are ignored while armed until a `hw_trig` pulse. A `sw_sync` pulse has no effect in this mode.
- R4: With `sync_mode` = 2 (software), capture starts after a `sw_sync` pulse. A `hw_trig` pulse and device writes before that strobe have no effect.
- R5: During capture, every cycle with `dev_wr_valid` high stores exactly one beat. After `DEPTH` stored beats, capture ends and `init_ack` falls.
- R6: Readout emits exactly `DEPTH` beats in write order. `m_tlast` is high on the final beat only. No beat follows the final beat.
- R7: While `m_tvalid` is high and `m_tready` is low, the next cycle shows the same `m_tvalid`, `m_tdata` and `m_tlast`.
- R8: Device writes that arrive after the storage is full do not change the stored data or the count. They set `dev_ovf`, which stays set until the next `init_req`.
- R9: `sample_count` is 64 bits wide. It rises by one for each stored beat and returns to 0 on `init_req`.
- R10: With `bypass` high, a device beat appears on `m_tdata` one cycle later, with `m_tvalid` high and `m_tlast` low, and nothing is stored.
- R11: A synchronous reset (`rst` high) drives `init_ack`, `m_tvalid`, `dev_ovf` and `sample_count` to 0 and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | One-cycle arm request; clears pointers, count and overflow |
| init_ack | output | 1 | High while the controller accepts or awaits samples |
| sync_mode | input | 2 | Start event: 0 automatic, 1 hardware trigger, 2 software strobe, 3 never |
| hw_trig | input | 1 | External start pulse (hardware mode) |
| sw_sync | input | 1 | Self-clearing software start strobe (software mode) |
| bypass | input | 1 | Route device beats directly to the stream output |
| dev_wr_valid | input | 1 | Device beat present this cycle |
| dev_wr_data | input | DW | Packed device beat |
| dev_ovf | output | 1 | Sticky flag: a beat arrived after the storage filled |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DW | Stream beat data |
| m_tlast | output | 1 | Final beat of the captured block |
| sample_count | output | 64 | Beats stored since the last arm |

## Verification
The bench tests the exact cycle in which capture opens in each start mode. If automatic capture began one cycle late, beat 0 would be lost and the block would shift by one. If a wrong-mode pulse were honoured, the count would rise while the controller should still be waiting. Readout is drained both with ready held high and with a periodic ready gap that lands on the first presented beat. A reader that advanced without a handshake would skip or repeat beats, and one that misplaced the last flag would end the packet early or never end it. Writes made after the storage fills, while the first beat is already waiting at the output, must leave the stored block intact and raise the overflow flag. Bypass beats, a re-arm in the middle of capture and a reset in the middle of capture must each leave the count and flags in their stated values.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_FILL  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } rxo_state_e;

  typedef enum logic [1:0] {
    SYNC_AUTO = 2'd0,
    SYNC_HW   = 2'd1,
    SYNC_SW   = 2'd2,
    SYNC_NONE = 2'd3
  } rxo_sync_e;
endpackage

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
  import rxo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init_req,
  input  rxo_sync_e  sync_mode,
  input  logic       hw_trig,
  input  logic       sw_sync,
  input  logic       cap_full,
  input  logic       rd_done,
  output rxo_state_e state
);
  rxo_state_e state_nx;
  logic       start_evt;

  always_comb begin
    case (sync_mode)
      SYNC_AUTO: start_evt = 1'b1;
      SYNC_HW:   start_evt = hw_trig;
      SYNC_SW:   start_evt = sw_sync;
      default:   start_evt = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state;
    if (init_req) begin
      state_nx = (sync_mode == SYNC_AUTO) ? ST_FILL : ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: if (start_evt) state_nx = ST_FILL;
        ST_FILL:  if (cap_full)  state_nx = ST_DRAIN;
        ST_DRAIN: if (rd_done)   state_nx = ST_DONE;
        default:  state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // R1
  init_ack_chk: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (state == ST_ARMED || state == ST_FILL));

  // R3
  armed_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && sync_mode == SYNC_HW && !hw_trig && !init_req)
      |=> state == ST_ARMED);
endmodule

// File: rtl/rxo_store.sv
module rxo_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          cap_full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (rst || clr)  wr_ptr <= '0;
    else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data  = mem[rd_addr];
  assign cap_full = wr_en && (wr_ptr == AW'(DEPTH - 1));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> wr_ptr == $past(wr_ptr) + 1'b1);
endmodule

// File: rtl/rxo_reader.sv
module rxo_reader #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          ready,
  input  logic [DW-1:0] mem_data,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          rd_done
);
  logic [CW-1:0] rd_cnt;
  logic          fetch;

  assign rd_addr = rd_cnt[AW-1:0];
  assign fetch   = en && (rd_cnt != CW'(DEPTH)) && (!out_valid || ready);
  assign rd_done = out_valid && out_last && ready;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_cnt    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (fetch) begin
      rd_cnt    <= rd_cnt + 1'b1;
      out_valid <= 1'b1;
      out_data  <= mem_data;
      out_last  <= (rd_cnt == CW'(DEPTH - 1));
    end else if (out_valid && ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // R7
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ready && !clr)
      |=> out_valid && $stable(out_data) && $stable(out_last));

  // R6
  last_final_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> rd_cnt == CW'(DEPTH));
endmodule

// File: rtl/rxo_capture_offload.sv
module rxo_capture_offload
  import rxo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  output logic          init_ack,
  input  logic [1:0]    sync_mode,
  input  logic          hw_trig,
  input  logic          sw_sync,
  input  logic          bypass,
  input  logic          dev_wr_valid,
  input  logic [DW-1:0] dev_wr_data,
  output logic          dev_ovf,
  output logic          m_tvalid,
  input  logic          m_tready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tlast,
  output logic [63:0]   sample_count
);
  rxo_state_e    state;
  logic          wr_en, cap_full, rd_done, is_full;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, rd_tdata, byp_data;
  logic          rd_tvalid, rd_tlast, byp_valid;

  assign wr_en   = (state == ST_FILL) && dev_wr_valid && !bypass && !init_req;
  assign is_full = (state == ST_DRAIN) || (state == ST_DONE);
  assign init_ack = (state == ST_ARMED) || (state == ST_FILL);

  rxo_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .init_req  (init_req),
    .sync_mode (rxo_sync_e'(sync_mode)),
    .hw_trig   (hw_trig),
    .sw_sync   (sw_sync),
    .cap_full  (cap_full),
    .rd_done   (rd_done),
    .state     (state)
  );

  rxo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (init_req),
    .wr_en    (wr_en),
    .wr_data  (dev_wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cap_full (cap_full)
  );

  rxo_reader #(.DW(DW), .DEPTH(DEPTH)) u_reader (
    .clk       (clk),
    .rst       (rst),
    .clr       (init_req),
    .en        (state == ST_DRAIN),
    .ready     (m_tready && !bypass),
    .mem_data  (rd_data),
    .rd_addr   (rd_addr),
    .out_valid (rd_tvalid),
    .out_data  (rd_tdata),
    .out_last  (rd_tlast),
    .rd_done   (rd_done)
  );

  always_ff @(posedge clk) begin
    if (rst || init_req)    sample_count <= '0;
    else if (wr_en)         sample_count <= sample_count + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || init_req)                        dev_ovf <= 1'b0;
    else if (dev_wr_valid && !bypass && is_full) dev_ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid <= 1'b0;
      byp_data  <= '0;
    end else begin
      byp_valid <= bypass && dev_wr_valid;
      byp_data  <= dev_wr_data;
    end
  end

  assign m_tvalid = bypass ? byp_valid : rd_tvalid;
  assign m_tdata  = bypass ? byp_data  : rd_tdata;
  assign m_tlast  = bypass ? 1'b0      : rd_tlast;

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_count != $past(sample_count))
      |-> (sample_count == $past(sample_count) + 64'd1 || sample_count == '0));

  // R8
  ovf_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_ovf) |-> ($past(state) == ST_DRAIN || $past(state) == ST_DONE));

  // R5
  ack_drop_full_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_count == 64'(DEPTH)) |-> !init_ack);

  // R10
  bypass_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !m_tlast);
endmodule

// File: tb/rxo_capture_offload_tb.sv
`timescale 1ns/1ps
module rxo_capture_offload_tb;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst, init_req, hw_trig, sw_sync, bypass, dev_wr_valid, m_tready;
  logic [1:0] sync_mode;
  logic [DW-1:0] dev_wr_data;
  logic init_ack, dev_ovf, m_tvalid, m_tlast;
  logic [DW-1:0] m_tdata;
  logic [63:0] sample_count;

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q [DEPTH];

  always #4 clk = ~clk;

  rxo_capture_offload #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
    .sync_mode(sync_mode), .hw_trig(hw_trig), .sw_sync(sw_sync),
    .bypass(bypass), .dev_wr_valid(dev_wr_valid), .dev_wr_data(dev_wr_data),
    .dev_ovf(dev_ovf), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .sample_count(sample_count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_init(input logic [1:0] mode);
    @(negedge clk);
    sync_mode = mode;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  // starts at a negedge, drives n beats (optionally with idle gaps), ends at a negedge
  task automatic write_beats(input int n, input logic [DW-1:0] base, input bit gaps, input bit rec);
    for (int i = 0; i < n; i++) begin
      dev_wr_valid = 1'b1;
      dev_wr_data  = base + DW'(i);
      if (rec) exp_q[i] = base + DW'(i);
      @(negedge clk);
      dev_wr_valid = 1'b0;
      if (gaps && (i % 2 == 0)) @(negedge clk);
    end
  endtask

  task automatic read_all(input int pat, input string tag);
    int got = 0;
    bit hold = 0;
    logic [DW-1:0] hd = '0;
    for (int c = 0; c < DEPTH * 4 + 8 && got < DEPTH; c++) begin
      m_tready = (pat == 0) ? 1'b1 : ((c % 3) != 1);
      if (hold) chk(m_tvalid && m_tdata == hd, {"R7 hold ", tag}, m_tdata, hd);
      hold = m_tvalid && !m_tready;
      hd = m_tdata;
      if (m_tvalid && m_tready) begin
        chk(m_tdata == exp_q[got], {"R6 data ", tag}, m_tdata, exp_q[got]);
        chk(m_tlast == (got == DEPTH - 1), {"R6 last ", tag}, m_tlast, got == DEPTH - 1);
        got++;
      end
      @(negedge clk);
    end
    m_tready = 1'b0;
    chk(got == DEPTH, {"R6 beat count ", tag}, got, DEPTH);
    repeat (3) @(negedge clk);
    chk(!m_tvalid, {"R6 no extra beat ", tag}, m_tvalid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!init_ack, "R11 ack after reset", init_ack, 0);
    chk(!m_tvalid, "R11 tvalid after reset", m_tvalid, 0);
    chk(!dev_ovf, "R11 ovf after reset", dev_ovf, 0);
    chk(sample_count == 0, "R11 count after reset", sample_count, 0);
  endtask

  task automatic t_auto_overflow();
    do_init(2'd0);
    chk(init_ack, "R1 ack after init", init_ack, 1);
    chk(sample_count == 0, "R9 count cleared", sample_count, 0);
    // R2: first beat driven in the first cycle ack reads high
    write_beats(DEPTH, 16'h1000, 1'b1, 1'b1);
    chk(sample_count == DEPTH, "R5 count full", sample_count, DEPTH);
    chk(!init_ack, "R5 ack drops when full", init_ack, 0);
    write_beats(2, 16'hBEEF, 1'b0, 1'b0);
    chk(dev_ovf, "R8 ovf set", dev_ovf, 1);
    chk(sample_count == DEPTH, "R8 count unchanged", sample_count, DEPTH);
    read_all(0, "auto R2");
    chk(dev_ovf, "R8 ovf sticky", dev_ovf, 1);
    do_init(2'd3);
    chk(!dev_ovf, "R8 ovf cleared by init", dev_ovf, 0);
  endtask

  task automatic t_hw_mode();
    do_init(2'd1);
    chk(init_ack, "R1 ack hw armed", init_ack, 1);
    write_beats(3, 16'h7777, 1'b0, 1'b0);
    sw_sync = 1'b1; @(negedge clk); sw_sync = 1'b0;
    write_beats(2, 16'h7700, 1'b0, 1'b0);
    chk(sample_count == 0, "R3 armed writes ignored", sample_count, 0);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    write_beats(DEPTH, 16'h2000, 1'b0, 1'b1);
    chk(sample_count == DEPTH, "R3 capture after trig", sample_count, DEPTH);
    read_all(1, "hw backpressure");
  endtask

  task automatic t_sw_mode();
    do_init(2'd2);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    write_beats(2, 16'h5500, 1'b0, 1'b0);
    chk(sample_count == 0, "R4 trig ignored in sw mode", sample_count, 0);
    chk(init_ack, "R4 still armed", init_ack, 1);
    sw_sync = 1'b1; @(negedge clk); sw_sync = 1'b0;
    write_beats(DEPTH, 16'h3000, 1'b1, 1'b1);
    chk(sample_count == DEPTH, "R4 capture after strobe", sample_count, DEPTH);
    read_all(1, "sw");
  endtask

  task automatic t_bypass_restart_reset();
    do_init(2'd1);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    bypass = 1'b1;
    dev_wr_valid = 1'b1; dev_wr_data = 16'hA5C3;
    @(negedge clk);
    dev_wr_valid = 1'b0;
    chk(m_tvalid && m_tdata == 16'hA5C3, "R10 bypass data", m_tdata, 16'hA5C3);
    chk(!m_tlast, "R10 bypass last low", m_tlast, 0);
    chk(sample_count == 0, "R10 bypass not stored", sample_count, 0);
    @(negedge clk);
    chk(!m_tvalid, "R10 bypass single beat", m_tvalid, 0);
    bypass = 1'b0;
    write_beats(3, 16'h4000, 1'b0, 1'b0);
    chk(sample_count == 3, "R9 partial count", sample_count, 3);
    do_init(2'd0);
    chk(sample_count == 0 && init_ack, "R9 re-arm clears count", sample_count, 0);
    write_beats(2, 16'h4100, 1'b0, 1'b0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(!init_ack && sample_count == 0, "R11 reset mid-capture", sample_count, 0);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; init_req = 1'b0; hw_trig = 1'b0; sw_sync = 1'b0; bypass = 1'b0;
    dev_wr_valid = 1'b0; dev_wr_data = '0; m_tready = 1'b0; sync_mode = 2'd0;
    t_reset();
    t_auto_overflow();
    t_hw_mode();
    t_sw_mode();
    t_bypass_restart_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule